// File: doc/BRIEF.md
# Watchdog Timer and Reset Generator

This block supervises a host processor. It watches a service input that the host pulses from high to low at regular intervals, and it drives an active-low reset line. Reset is held at power-up and whenever a supply-good flag from an external trip comparator is low. It is also held for a fixed release delay after the host stops servicing the watchdog within the selected window.

A two-bit setting picks one of three timeout windows or turns the watchdog off. All delays are counted in ticks of an internal prescaled timebase. The tick length and every delay length are parameters, so the nominal millisecond values can be scaled down for simulation. Every release of reset restarts both the prescaler and the watchdog count, so each window is measured from a known edge.

Top module: `wdr_supervisor`

## Requirements
- R1: `periodSel` selects the watchdog window: 2'b00 gives LONG_TICKS (1.4 s nominal), 2'b01 gives MID_TICKS (600 ms), and 2'b10 gives SHORT_TICKS (200 ms). Without service, `resetN` falls exactly window×TICK_CYCLES clock cycles after the clock edge on which it rose.
- R2: `periodSel` = 2'b11 disables the watchdog. While the supply stays good, `resetN` then never falls.
- R3: Only a high-to-low transition of `wdiIn` restarts the window. If the input is driven low just after edge f, the timeout fires at edge f+3+window×TICK_CYCLES (a two-flop synchroniser plus one edge-detect stage). A low-to-high transition has no effect.
- R4: A `wdiIn` held steadily high or steadily low lets the window expire.
- R5: After a watchdog timeout, `resetN` stays low for exactly HOLD_TICKS×TICK_CYCLES cycles and then goes high.
- R6: After `rstN` releases, `resetN` is low and stays low for exactly HOLD_TICKS×TICK_CYCLES cycles.
- R7: When `supplyOk` is sampled low, `resetN` is low from the next edge on and stays low while the flag is low.
- R8: `resetN` goes high only after `supplyOk` has been high for HOLD_TICKS×TICK_CYCLES consecutive cycles. A drop during the delay restarts it.
- R9: Watchdog service during reset has no effect. The window always starts fresh at the edge where `resetN` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| wdiIn | input | 1 | Watchdog service input, asynchronous, falling edge restarts the window |
| supplyOk | input | 1 | Supply-good flag from the trip comparator, high when the supply is good |
| periodSel | input | 2 | Window select: 00 long, 01 middle, 10 short, 11 disabled |
| resetN | output | 1 | Reset output, active low |

## Verification
A wrong prescaler or counter state shows up as a reset edge that arrives early or late. The bench measures every high and low stretch of `resetN` to the exact cycle, so an off-by-one error appears within a single window. A wrongly kept watchdog count or a missed service edge shows up as a timeout at the wrong cycle after a kick. A stuck control state shows up as a release that never happens, or a reset that never asserts, within one hold or one window.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } supState_t;

  typedef struct packed {
    logic clrBase;
    logic clrWdog;
    logic clrHold;
  } wdrStrobe_t;

  localparam logic [1:0] SEL_LONG  = 2'b00;
  localparam logic [1:0] SEL_MID   = 2'b01;
  localparam logic [1:0] SEL_SHORT = 2'b10;
  localparam logic [1:0] SEL_OFF   = 2'b11;

endpackage

// File: rtl/wdr_datapath.sv
module wdr_datapath
  import wdr_pkg::*;
#(
  parameter int TICK_CYCLES = 50000,
  parameter int HOLD_TICKS  = 200,
  parameter int LONG_TICKS  = 1400,
  parameter int MID_TICKS   = 600,
  parameter int SHORT_TICKS = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdiIn,
  input  logic [1:0] periodSel,
  input  wdrStrobe_t strobe,
  output logic       fallEdge,
  output logic       wdDone,
  output logic       holdDone
);

  localparam int BASE_W = $clog2(TICK_CYCLES + 1);
  localparam int WD_W   = $clog2(LONG_TICKS + 1);
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1);

  localparam logic [BASE_W-1:0] BASE_LAST  = BASE_W'(TICK_CYCLES - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST  = HOLD_W'(HOLD_TICKS - 1);
  localparam logic [WD_W-1:0]   LONG_LAST  = WD_W'(LONG_TICKS - 1);
  localparam logic [WD_W-1:0]   MID_LAST   = WD_W'(MID_TICKS - 1);
  localparam logic [WD_W-1:0]   SHORT_LAST = WD_W'(SHORT_TICKS - 1);

  // input synchroniser and edge detect
  logic wdiMeta, wdiSync, wdiPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdiMeta <= 1'b1;
      wdiSync <= 1'b1;
      wdiPrev <= 1'b1;
    end else begin
      wdiMeta <= wdiIn;
      wdiSync <= wdiMeta;
      wdiPrev <= wdiSync;
    end
  end

  assign fallEdge = wdiPrev & ~wdiSync;

  // prescaled timebase
  logic [BASE_W-1:0] baseCnt;
  logic              tick;

  assign tick = (baseCnt == BASE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              baseCnt <= '0;
    else if (strobe.clrBase) baseCnt <= '0;
    else if (tick)           baseCnt <= '0;
    else                     baseCnt <= baseCnt + 1'b1;
  end

  // watchdog window counter
  logic [WD_W-1:0] wdCnt;
  logic [WD_W-1:0] wdLast;
  logic            wdEnabled;

  always_comb begin
    wdEnabled = 1'b1;
    wdLast    = SHORT_LAST;
    unique case (periodSel)
      SEL_LONG:  wdLast = LONG_LAST;
      SEL_MID:   wdLast = MID_LAST;
      SEL_SHORT: wdLast = SHORT_LAST;
      default:   wdEnabled = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            wdCnt <= '0;
    else if (strobe.clrWdog || !wdEnabled) wdCnt <= '0;
    else if (tick)                         wdCnt <= wdCnt + 1'b1;
  end

  assign wdDone = wdEnabled && tick && (wdCnt >= wdLast);

  // reset release delay counter
  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdCnt <= '0;
    else if (strobe.clrHold) holdCnt <= '0;
    else if (tick)           holdCnt <= holdCnt + 1'b1;
  end

  assign holdDone = tick && (holdCnt == HOLD_LAST);

endmodule

// File: rtl/wdr_control.sv
module wdr_control
  import wdr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       fallEdge,
  input  logic       wdDone,
  input  logic       holdDone,
  output wdrStrobe_t strobe,
  output logic       resetN
);

  supState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_HOLD: begin
        strobe.clrWdog = 1'b1;
        if (!supplyOk) begin
          strobe.clrBase = 1'b1;
          strobe.clrHold = 1'b1;
        end else if (holdDone) begin
          stateNext      = ST_RUN;
          strobe.clrBase = 1'b1;
          strobe.clrHold = 1'b1;
        end
      end
      default: begin
        strobe.clrHold = 1'b1;
        if (!supplyOk) begin
          stateNext      = ST_HOLD;
          strobe.clrBase = 1'b1;
          strobe.clrWdog = 1'b1;
        end else if (fallEdge) begin
          strobe.clrBase = 1'b1;
          strobe.clrWdog = 1'b1;
        end else if (wdDone) begin
          stateNext      = ST_HOLD;
          strobe.clrBase = 1'b1;
          strobe.clrWdog = 1'b1;
        end
      end
    endcase
  end

  assign resetN = (state == ST_RUN);

endmodule

// File: rtl/wdr_supervisor.sv
module wdr_supervisor
  import wdr_pkg::*;
#(
  parameter int TICK_CYCLES = 50000,
  parameter int HOLD_TICKS  = 200,
  parameter int LONG_TICKS  = 1400,
  parameter int MID_TICKS   = 600,
  parameter int SHORT_TICKS = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdiIn,
  input  logic       supplyOk,
  input  logic [1:0] periodSel,
  output logic       resetN
);

  wdrStrobe_t strobe;
  logic       fallEdge, wdDone, holdDone;

  wdr_datapath #(
    .TICK_CYCLES(TICK_CYCLES),
    .HOLD_TICKS (HOLD_TICKS),
    .LONG_TICKS (LONG_TICKS),
    .MID_TICKS  (MID_TICKS),
    .SHORT_TICKS(SHORT_TICKS)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .wdiIn    (wdiIn),
    .periodSel(periodSel),
    .strobe   (strobe),
    .fallEdge (fallEdge),
    .wdDone   (wdDone),
    .holdDone (holdDone)
  );

  wdr_control u_control (
    .clk     (clk),
    .rstN    (rstN),
    .supplyOk(supplyOk),
    .fallEdge(fallEdge),
    .wdDone  (wdDone),
    .holdDone(holdDone),
    .strobe  (strobe),
    .resetN  (resetN)
  );

endmodule

// File: rtl/wdr_checker.sv
module wdr_checker #(
  parameter int TICK_CYCLES = 50000,
  parameter int HOLD_TICKS  = 200,
  parameter int LONG_TICKS  = 1400,
  parameter int MID_TICKS   = 600,
  parameter int SHORT_TICKS = 200
) (
  input logic       clk,
  input logic       rstN,
  input logic       supplyOk,
  input logic [1:0] periodSel,
  input logic       resetN
);

  localparam logic [31:0] HOLD_CYC  = 32'(HOLD_TICKS * TICK_CYCLES);
  localparam logic [31:0] SHORT_CYC = 32'(SHORT_TICKS * TICK_CYCLES);

  logic [31:0] lowCnt, highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      highCnt <= '0;
    end else begin
      lowCnt  <= resetN ? '0 : lowCnt + 1'b1;
      highCnt <= resetN ? highCnt + 1'b1 : '0;
    end
  end

  // R7
  supply_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> !resetN);

  // R8
  release_good_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> $past(supplyOk));

  // R5
  hold_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> (lowCnt >= HOLD_CYC));

  // R1
  min_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(resetN) && $past(supplyOk)) |-> (highCnt >= SHORT_CYC));

  // R2
  wd_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resetN && supplyOk && periodSel == 2'b11) |=> resetN);

endmodule

bind wdr_supervisor wdr_checker #(
  .TICK_CYCLES(TICK_CYCLES),
  .HOLD_TICKS (HOLD_TICKS),
  .LONG_TICKS (LONG_TICKS),
  .MID_TICKS  (MID_TICKS),
  .SHORT_TICKS(SHORT_TICKS)
) u_wdr_checker (
  .clk      (clk),
  .rstN     (rstN),
  .supplyOk (supplyOk),
  .periodSel(periodSel),
  .resetN   (resetN)
);

// File: tb/test_wdr_supervisor.sv
`timescale 1ns/1ps
module test_wdr_supervisor;

  localparam int TB_TICK  = 2;
  localparam int TB_HOLD  = 20;
  localparam int TB_LONG  = 140;
  localparam int TB_MID   = 60;
  localparam int TB_SHORT = 20;
  localparam int HOLD_CYC = TB_HOLD * TB_TICK;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wdiIn = 1'b1;
  logic       supplyOk = 1'b1;
  logic [1:0] periodSel = 2'b10;
  logic       resetN;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  wdr_supervisor #(
    .TICK_CYCLES(TB_TICK),
    .HOLD_TICKS (TB_HOLD),
    .LONG_TICKS (TB_LONG),
    .MID_TICKS  (TB_MID),
    .SHORT_TICKS(TB_SHORT)
  ) i_wdr_supervisor (
    .clk      (clk),
    .rstN     (rstN),
    .wdiIn    (wdiIn),
    .supplyOk (supplyOk),
    .periodSel(periodSel),
    .resetN   (resetN)
  );

  always #10 clk = ~clk;

  function automatic int expWindow(input logic [1:0] sel);
    case (sel)
      2'b00:   return TB_LONG * TB_TICK;
      2'b01:   return TB_MID * TB_TICK;
      2'b10:   return TB_SHORT * TB_TICK;
      default: return 0;
    endcase
  endfunction

  function automatic int expKicked(input logic [1:0] sel, input int fallAt);
    return fallAt + 3 + expWindow(sel);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts edges until resetN leaves the level given by wantLow
  task automatic runPhase(input bit wantLow, input int riseAt, input int fallAt, output int n);
    bit stop;
    n = 0;
    stop = 0;
    while (!stop) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == riseAt) wdiIn = 1'b1;
      if (n == fallAt) wdiIn = 1'b0;
      if ((resetN == 1'b0) != wantLow) stop = 1;
      else if (n > 20000) stop = 1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    int f;
    int stuck;
    void'($urandom(32'd24680));

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(resetN == 1'b0, "R6 reset state", resetN, 0);
    rstN = 1'b1;

    // R6 power-up hold
    runPhase(1, -1, -1, n);
    check(n == HOLD_CYC, "R6 power-up hold", n, HOLD_CYC);

    // R1 / R4 short window, input steady high
    runPhase(0, -1, -1, n);
    check(n == expWindow(2'b10), "R1 R4 short window steady high", n, expWindow(2'b10));

    // R5 hold after timeout, R9 service during hold ignored
    periodSel = 2'b00;
    runPhase(1, 5, 9, n);
    check(n == HOLD_CYC, "R5 R9 hold with service pulses", n, HOLD_CYC);

    // R1 / R4 / R9 long window, input steady low, fresh start
    runPhase(0, -1, -1, n);
    check(n == expWindow(2'b00), "R1 R4 R9 long window steady low", n, expWindow(2'b00));
    runPhase(1, -1, -1, n);
    check(n == HOLD_CYC, "R5 hold after long", n, HOLD_CYC);

    // R3 rising edge ignored, middle window
    periodSel = 2'b01;
    runPhase(0, 30, -1, n);
    check(n == expWindow(2'b01), "R3 rise ignored middle window", n, expWindow(2'b01));
    runPhase(1, -1, -1, n);
    check(n == HOLD_CYC, "R5 hold after middle", n, HOLD_CYC);

    // R3 falling edge restarts
    runPhase(0, -1, 50, n);
    check(n == expKicked(2'b01, 50), "R3 fall restarts window", n, expKicked(2'b01, 50));
    runPhase(1, -1, -1, n);
    check(n == HOLD_CYC, "R5 hold after kick", n, HOLD_CYC);

    // R3 random service points over random windows
    for (int i = 0; i < 6; i++) begin
      periodSel = 2'($urandom % 3);
      f = 5 + int'($urandom % (expWindow(periodSel) - 20));
      runPhase(0, 1, f, n);
      check(n == expKicked(periodSel, f), "R3 random kick", n, expKicked(periodSel, f));
      runPhase(1, -1, -1, n);
      check(n == HOLD_CYC, "R5 random hold", n, HOLD_CYC);
    end

    // R2 disabled watchdog
    periodSel = 2'b11;
    stuck = 0;
    for (int i = 0; i < 2 * expWindow(2'b00); i++) begin
      @(posedge clk);
      @(negedge clk);
      if (resetN != 1'b1) stuck++;
    end
    check(stuck == 0, "R2 disabled never expires", stuck, 0);

    // R7 supply drop
    supplyOk = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(resetN == 1'b0, "R7 reset on supply drop", resetN, 0);
    stuck = 0;
    for (int i = 0; i < 3 * HOLD_CYC; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (resetN != 1'b0) stuck++;
    end
    check(stuck == 0, "R7 held while supply low", stuck, 0);

    // R8 release after supply good
    supplyOk = 1'b1;
    runPhase(1, -1, -1, n);
    check(n == HOLD_CYC, "R8 release delay", n, HOLD_CYC);

    // R8 glitch during delay restarts it
    supplyOk = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    supplyOk = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(resetN == 1'b0, "R8 still low mid delay", resetN, 0);
    supplyOk = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    supplyOk = 1'b1;
    runPhase(1, -1, -1, n);
    check(n == HOLD_CYC, "R8 delay restarted by glitch", n, HOLD_CYC);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule